// File: doc/BRIEF.md
# Bit-Six Watchdog Timer

This block is a software-serviced watchdog. A single 8-bit control register holds an arming flag in its top bit and a 7-bit down-counter in the lower seven bits. The counter steps down by one after each full period of a fixed clock prescaler. The default period is 49152 clock cycles. Software sets the timeout by choosing the value it loads into the counter. Usable loads run from 40h to 7Fh, which gives 64 steps of timeout length.

Once armed, the watchdog asks for a system reset as soon as counter bit 6 is found clear. In normal operation this happens when the counter steps from 40h to 3Fh. Software keeps the system alive by rewriting the counter before that step happens. Every write also restarts the prescaler. When the reset request fires, the block puts itself back in its reset state, so the request is a single-cycle pulse. While the block is disarmed, the counter keeps stepping down and wrapping, but it never requests a reset.

Top module: `bitsix_watchdog`

## Requirements
- R1: While `rst` is high and after it is released, `ctl_rdata` reads 8'h7F (disarmed, counter 7Fh) and `wdt_reset_req` is 0.
- R2: A cycle with `ctl_we` high loads `ctl_wdata[6:0]` into the counter. From the next cycle on, `ctl_rdata[6:0]` reads that value and `ctl_rdata[7]` reads the arming flag.
- R3: With no write, the counter drops by one every PRESCALE cycles and wraps from 00h to 7Fh.
- R4: A write restarts the prescaler. The first decrement after a write appears exactly PRESCALE cycles after the write edge, and no earlier.
- R5: Writing 1 to bit 7 arms the block. A later write with bit 7 at 0 leaves it armed. Only `rst` or a reset request disarms it.
- R6: If the block is armed with counter value v (40h..7Fh) and nothing else happens, `wdt_reset_req` goes high exactly (v-3Fh)*PRESCALE+1 cycles after the write edge.
- R7: An armed write with bit 6 at 0 raises `wdt_reset_req` on the next cycle.
- R8: While disarmed, `wdt_reset_req` stays 0, including when the counter crosses from 40h to 3Fh.
- R9: `wdt_reset_req` is high for exactly one cycle. In that same cycle `ctl_rdata` already reads 8'h7F.
- R10: If software rewrites a counter value with bit 6 set before the step to 3Fh, the armed block never requests a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Write data: bit 7 arm, bits 6:0 counter |
| ctl_rdata | output | 8 | Register contents: bit 7 armed, bits 6:0 counter |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
The hardest situation to reach is the exact cycle of the timeout. With the full prescale constant it sits millions of cycles away. The bench therefore shrinks PRESCALE to 8 and counts edges from the arming write to the pulse, for several starting values up to 7Fh. It compares each count with (v-3Fh)*8+1. Two more cases need precise timing. Restarting the prescaler is tested by rewriting in the middle of a period and confirming that the next step comes a full period later. The refresh case writes again every two periods and watches that no pulse appears across many would-be timeouts.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int WDG_CNT_W = 7;

  typedef struct packed {
    logic                 armed;
    logic [WDG_CNT_W-1:0] cnt;
  } wdg_reg_t;

  localparam wdg_reg_t WDG_REG_RST = '{armed: 1'b0, cnt: '1};
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int PRESCALE = 49152
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
  import wdg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 we,
  input  logic [WDG_CNT_W:0]   wdata,
  input  logic                 tick,
  output wdg_reg_t             reg_q
);
  always_ff @(posedge clk) begin
    if (rst || fire) begin
      reg_q <= WDG_REG_RST;
    end else if (we) begin
      reg_q.cnt   <= wdata[WDG_CNT_W-1:0];
      reg_q.armed <= reg_q.armed | wdata[WDG_CNT_W];
    end else if (tick) begin
      reg_q.cnt   <= reg_q.cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wdg_reg_t reg_q,
  output logic     fire,
  output logic     req_q
);
  assign fire = reg_q.armed & ~reg_q.cnt[WDG_CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= fire;
  end
endmodule

// File: rtl/bitsix_watchdog.sv
module bitsix_watchdog
  import wdg_pkg::*;
#(
  parameter int PRESCALE = 49152
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [WDG_CNT_W:0] ctl_wdata,
  output logic [WDG_CNT_W:0] ctl_rdata,
  output logic               wdt_reset_req
);
  wdg_reg_t reg_q;
  logic     tick;
  logic     fire;

  wdg_prescale #(.PRESCALE(PRESCALE)) pre_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctl_we | fire),
    .tick (tick)
  );

  wdg_ctl_reg reg_i (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .tick  (tick),
    .reg_q (reg_q)
  );

  wdg_pulse pulse_i (
    .clk   (clk),
    .rst   (rst),
    .reg_q (reg_q),
    .fire  (fire),
    .req_q (wdt_reset_req)
  );

  assign ctl_rdata = reg_q;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctl_we,
  input logic [7:0] ctl_rdata,
  input logic       wdt_reset_req
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |=> !wdt_reset_req); // R9
  AST_PULSE_RESTORE: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |-> (ctl_rdata == 8'h7F)); // R9
  AST_NO_FIRE_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[7] |=> !wdt_reset_req); // R8
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[7] |=> (ctl_rdata[7] || wdt_reset_req)); // R5
  AST_LOW_BIT6_FIRES: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[7] && !ctl_rdata[6]) |=> wdt_reset_req); // R7
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> (wdt_reset_req || ctl_rdata[6:0] == $past(ctl_rdata[6:0])
                 || ctl_rdata[6:0] == 7'($past(ctl_rdata[6:0]) - 7'd1))); // R3
endmodule

bind bitsix_watchdog wdg_checker chk_i (
  .clk           (clk),
  .rst           (rst),
  .ctl_we        (ctl_we),
  .ctl_rdata     (ctl_rdata),
  .wdt_reset_req (wdt_reset_req)
);

// File: tb/bitsix_watchdog_tb_top.sv
`timescale 1ns/1ps
module bitsix_watchdog_tb_top;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       wdt_reset_req;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bitsix_watchdog #(.PRESCALE(P)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .ctl_we        (ctl_we),
    .ctl_wdata     (ctl_wdata),
    .ctl_rdata     (ctl_rdata),
    .wdt_reset_req (wdt_reset_req)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    chk("R1 reset rdata", ctl_rdata, 8'h7F);
    rst = 1'b0;
    chk("R1 reset req", wdt_reset_req, 0);

    // R2 R3 R4: disarmed sweep over every counter value
    for (int v = 0; v < 128; v++) begin
      wr(8'(v));
      chk("R2 load", ctl_rdata, v);
      repeat (P - 1) step();
      chk("R4 no early step", ctl_rdata, v);
      step();
      chk("R3 decrement/wrap", ctl_rdata, (v - 1) & 8'h7F);
      chk("R8 no req disarmed", wdt_reset_req, 0);
    end

    // R4: rewrite mid-period restarts the prescaler
    wr(8'h50);
    repeat (3) step();
    wr(8'h50);
    repeat (P - 1) step();
    chk("R4 restart hold", ctl_rdata, 8'h50);
    step();
    chk("R4 restart step", ctl_rdata, 8'h4F);

    // R8: disarmed crossing of 40h -> 3Fh
    wr(8'h41);
    n = 0;
    for (int i = 0; i < 3 * P; i++) begin
      step();
      if (wdt_reset_req) n++;
    end
    chk("R8 no req on crossing", n, 0);
    chk("R8 counter kept running", ctl_rdata, 8'h3E);

    // R6 R9: armed timeout length for several loads
    for (int v = 8'h40; v <= 8'h7F; v += 9) begin
      wr(8'h80 | 8'(v));
      n = 0;
      while (!wdt_reset_req && n < 2000) begin
        step();
        n++;
      end
      chk("R6 timeout cycles", n, (v - 8'h3F) * P + 1);
      chk("R9 restored with pulse", ctl_rdata, 8'h7F);
      step();
      chk("R9 single cycle", wdt_reset_req, 0);
    end

    // R5: arming is sticky
    wr(8'hFF);
    wr(8'h70);
    chk("R5 sticky arm", ctl_rdata, 8'hF0);
    do_reset();
    chk("R1 rst disarms", ctl_rdata, 8'h7F);

    // R7: armed write with bit 6 clear
    wr(8'hA0);
    chk("R7 no req yet", wdt_reset_req, 0);
    chk("R7 loaded", ctl_rdata, 8'hA0);
    step();
    chk("R7 req next cycle", wdt_reset_req, 1);
    chk("R9 restored", ctl_rdata, 8'h7F);
    step();
    chk("R9 pulse ended", wdt_reset_req, 0);

    // R10: periodic refresh keeps the system alive
    wr(8'hC2);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      repeat (2 * P) begin
        step();
        if (wdt_reset_req) n++;
      end
      wr(8'h42);
    end
    chk("R10 no pulse with refresh", n, 0);
    chk("R10 still armed", ctl_rdata, 8'hC2);

    // R1: reset in mid countdown
    repeat (5) step();
    do_reset();
    chk("R1 mid-run reset", ctl_rdata, 8'h7F);
    chk("R1 mid-run req", wdt_reset_req, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule